// File: doc/BRIEF.md
# Dual Watchdog Timer Unit

This block holds a parameterised number of identical watchdog channels, two by default, behind a small register port. Each channel has a 16-bit down-counter, a preset value, and a choice of two tick rates. Software arms a channel by writing a two-step key pattern to the control register. It keeps the channel alive by writing the same pattern to a second key field before the counter reaches zero. A channel that runs out raises the shared reset request for a fixed number of clocks and then records a sticky expiry flag.

Two chained prescalers make both tick rates from the one system clock. The fast tick is a single-cycle pulse every `FAST_DIV` clocks. The slow tick is a single-cycle pulse every `SLOW_DIV` fast ticks. The two resulting timeout ranges overlap. Software can read each channel's state at any time: enable, expiry, tick selection and the live count.

Top module: `wdt_dual_unit`

## Requirements
- R1: After `rst_n` is low, every channel reads as disabled, not expired, slow tick selected, count 0 and preset 0, and `wdt_rst_o` is low.
- R2: Register address bit 0 selects the register: 0 is the preset and 1 is control/status. The upper address bits give the channel index. A preset read returns the preset in bits [CNT_W-1:0]. A status read returns bit 0 = enabled, bit 1 = expired, bit 2 = fast tick selected, and the count in the top CNT_W bits.
- R3: A control write with bits [1:0] = 01, followed by the next control write with bits [1:0] = 10, enables the channel and loads the count from the preset.
- R4: A value 10 in bits [1:0] that does not directly follow a control write of 01 does not arm the channel. Any other control write between the two halves cancels the pattern.
- R5: The pattern 01 then 10 in control bits [3:2] reloads the count from the preset while the channel is enabled. The same pattern has no effect on a disabled channel.
- R6: A service pattern that is broken by another control write does not reload the count.
- R7: With control bit 4 = 1, the count of an enabled channel drops by one every FAST_DIV clocks.
- R8: With control bit 4 = 0, which is the reset default, the count drops by one every FAST_DIV*SLOW_DIV clocks.
- R9: One clock after an enabled channel's count reaches zero, `wdt_rst_o` rises and the channel is disabled. `wdt_rst_o` stays high for exactly RST_CYCLES clocks.
- R10: The expired flag is set in the clock where the reset request ends. Only `rst_n` clears it.
- R11: The channels are independent. Activity on one channel never changes another channel's state.
- R12: An armed channel with preset P reaches zero after exactly P single-step decrements, with no wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous block reset |
| reg_wr_i | input | 1 | Register write strobe, one cycle per write |
| reg_addr_i | input | ADDR_W | {channel index, register select} |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Combinational read data for reg_addr_i |
| wdt_rst_o | output | 1 | Reset request, OR of all channels |

## Verification
The main function is swept over every channel, both tick selections and presets 1 to 4 in a small configuration. Fast and slow runs are told apart by the measured spacing between decrements. Miscounted or wrapping counters are caught by the number of steps taken to reach zero. The one-clock delay from reaching zero, the exact pulse width and the moment the expiry flag is set are all checked to the cycle. Separate patterns cover key sequences that are complete, lone, interrupted or restarted, for both arming and service. Service on a disabled channel is checked alongside them, so an order-insensitive or level-sensitive key detector fails where a correct one arms or reloads.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
   typedef enum logic {
      KS_IDLE,
      KS_HALF
   } key_state_t;

   localparam logic [1:0] KEY_OPEN  = 2'b01;
   localparam logic [1:0] KEY_CLOSE = 2'b10;

   // control write field layout
   localparam int CTRL_W  = 5;
   localparam int ARM_LSB = 0;
   localparam int SVC_LSB = 2;
   localparam int SEL_BIT = 4;

   // status read field layout (count sits in the top bits)
   localparam int ST_EN  = 0;
   localparam int ST_EXP = 1;
   localparam int ST_SEL = 2;
endpackage

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
   parameter int DIV = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic adv_i,
   output logic pulse_o
);
   generate
      if (DIV < 1) begin : g_bad
         $error("wdt_prescale: DIV must be at least 1");
      end
      if (DIV == 1) begin : g_pass
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign pulse_o = adv_i;
      end else begin : g_div
         localparam int W = $clog2(DIV);
         localparam logic [W-1:0] LAST = W'(DIV - 1);
         logic [W-1:0] cnt_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (adv_i) begin
               cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
            end
         end
         assign pulse_o = adv_i && (cnt_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/wdt_key_seq.sv
module wdt_key_seq
   import wdt_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_i,
   input  logic [1:0] key_i,
   output logic       fire_o
);
   key_state_t state_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= KS_IDLE;
      end else if (wr_i) begin
         state_q <= (key_i == KEY_OPEN) ? KS_HALF : KS_IDLE;
      end
   end

   assign fire_o = wr_i && (state_q == KS_HALF) && (key_i == KEY_CLOSE);
endmodule

// File: rtl/wdt_channel.sv
module wdt_channel
   import wdt_pkg::*;
#(
   parameter int CNT_W      = 16,
   parameter int DATA_W     = 32,
   parameter int RST_CYCLES = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_fast_i,
   input  logic              tick_slow_i,
   input  logic              wr_preset_i,
   input  logic              wr_ctrl_i,
   input  logic [CNT_W-1:0]  preset_d_i,
   input  logic [CTRL_W-1:0] ctrl_d_i,
   output logic [CNT_W-1:0]  preset_o,
   output logic [DATA_W-1:0] status_o,
   output logic [CNT_W-1:0]  cnt_o,
   output logic              en_o,
   output logic              exp_o,
   output logic              busy_o,
   output logic              arm_o,
   output logic              svc_o
);
   localparam int HOLD_W = $clog2(RST_CYCLES + 1);
   localparam logic [HOLD_W-1:0] HOLD_LOAD = HOLD_W'(RST_CYCLES);

   logic [CNT_W-1:0]  preset_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [HOLD_W-1:0] hold_q;
   logic              en_q;
   logic              exp_q;
   logic              sel_fast_q;
   logic              arm_fire;
   logic              svc_fire;
   logic              tick;

   wdt_key_seq u_arm_key (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_i   (wr_ctrl_i),
      .key_i  (ctrl_d_i[ARM_LSB +: 2]),
      .fire_o (arm_fire)
   );

   wdt_key_seq u_svc_key (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_i   (wr_ctrl_i),
      .key_i  (ctrl_d_i[SVC_LSB +: 2]),
      .fire_o (svc_fire)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         preset_q   <= '0;
         sel_fast_q <= 1'b0;
      end else begin
         if (wr_preset_i) preset_q <= preset_d_i;
         if (wr_ctrl_i)   sel_fast_q <= ctrl_d_i[SEL_BIT];
      end
   end

   assign tick = sel_fast_q ? tick_fast_i : tick_slow_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         exp_q  <= 1'b0;
         cnt_q  <= '0;
         hold_q <= '0;
      end else begin
         if (hold_q != '0) begin
            hold_q <= hold_q - 1'b1;
            if (hold_q == HOLD_W'(1)) exp_q <= 1'b1;
         end
         if (arm_fire && (hold_q == '0)) begin
            en_q  <= 1'b1;
            cnt_q <= preset_q;
         end else if (en_q) begin
            if (cnt_q == '0) begin
               en_q   <= 1'b0;
               hold_q <= HOLD_LOAD;
            end else if (svc_fire) begin
               cnt_q <= preset_q;
            end else if (tick) begin
               cnt_q <= cnt_q - 1'b1;
            end
         end
      end
   end

   always_comb begin
      status_o                     = '0;
      status_o[ST_EN]              = en_q;
      status_o[ST_EXP]             = exp_q;
      status_o[ST_SEL]             = sel_fast_q;
      status_o[DATA_W-1 -: CNT_W]  = cnt_q;
   end

   assign preset_o = preset_q;
   assign cnt_o    = cnt_q;
   assign en_o     = en_q;
   assign exp_o    = exp_q;
   assign busy_o   = (hold_q != '0);
   assign arm_o    = arm_fire;
   assign svc_o    = svc_fire;
endmodule

// File: rtl/wdt_dual_unit.sv
module wdt_dual_unit
   import wdt_pkg::*;
#(
   parameter int N_TIMERS   = 2,
   parameter int CNT_W      = 16,
   parameter int DATA_W     = 32,
   parameter int FAST_DIV   = 5,
   parameter int SLOW_DIV   = 8000,
   parameter int RST_CYCLES = 16,
   localparam int IDX_W     = (N_TIMERS > 1) ? $clog2(N_TIMERS) : 1,
   localparam int ADDR_W    = IDX_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_i,
   input  logic [ADDR_W-1:0] reg_addr_i,
   input  logic [DATA_W-1:0] reg_wdata_i,
   output logic [DATA_W-1:0] reg_rdata_o,
   output logic              wdt_rst_o
);
   generate
      if (N_TIMERS < 1) begin : g_bad_n
         $error("wdt_dual_unit: N_TIMERS must be at least 1");
      end
      if (DATA_W < CNT_W + 3) begin : g_bad_w
         $error("wdt_dual_unit: DATA_W too narrow for status layout");
      end
      if (RST_CYCLES < 1) begin : g_bad_r
         $error("wdt_dual_unit: RST_CYCLES must be at least 1");
      end
   endgenerate

   logic tick_fast;
   logic tick_slow;

   logic [N_TIMERS-1:0]             ch_en;
   logic [N_TIMERS-1:0]             ch_exp;
   logic [N_TIMERS-1:0]             ch_busy;
   logic [N_TIMERS-1:0]             ch_arm;
   logic [N_TIMERS-1:0]             ch_svc;
   logic [N_TIMERS-1:0][CNT_W-1:0]  ch_cnt;
   logic [N_TIMERS-1:0][CNT_W-1:0]  ch_preset;
   logic [N_TIMERS-1:0][DATA_W-1:0] ch_status;

   logic unused_wdata;
   assign unused_wdata = ^reg_wdata_i[DATA_W-1:CNT_W];

   wdt_prescale #(.DIV(FAST_DIV)) u_fast_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .adv_i   (1'b1),
      .pulse_o (tick_fast)
   );

   wdt_prescale #(.DIV(SLOW_DIV)) u_slow_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .adv_i   (tick_fast),
      .pulse_o (tick_slow)
   );

   genvar gi;
   generate
      for (gi = 0; gi < N_TIMERS; gi++) begin : g_ch
         logic hit;
         assign hit = reg_wr_i && (reg_addr_i[ADDR_W-1:1] == IDX_W'(gi));

         wdt_channel #(
            .CNT_W      (CNT_W),
            .DATA_W     (DATA_W),
            .RST_CYCLES (RST_CYCLES)
         ) u_ch (
            .clk         (clk),
            .rst_n       (rst_n),
            .tick_fast_i (tick_fast),
            .tick_slow_i (tick_slow),
            .wr_preset_i (hit && !reg_addr_i[0]),
            .wr_ctrl_i   (hit && reg_addr_i[0]),
            .preset_d_i  (reg_wdata_i[CNT_W-1:0]),
            .ctrl_d_i    (reg_wdata_i[CTRL_W-1:0]),
            .preset_o    (ch_preset[gi]),
            .status_o    (ch_status[gi]),
            .cnt_o       (ch_cnt[gi]),
            .en_o        (ch_en[gi]),
            .exp_o       (ch_exp[gi]),
            .busy_o      (ch_busy[gi]),
            .arm_o       (ch_arm[gi]),
            .svc_o       (ch_svc[gi])
         );
      end
   endgenerate

   always_comb begin
      reg_rdata_o = '0;
      for (int k = 0; k < N_TIMERS; k++) begin
         if (reg_addr_i[ADDR_W-1:1] == IDX_W'(k)) begin
            reg_rdata_o = reg_addr_i[0] ? ch_status[k] : DATA_W'(ch_preset[k]);
         end
      end
   end

   assign wdt_rst_o = |ch_busy;
endmodule

module wdt_dual_chk #(
   parameter int N_TIMERS = 2,
   parameter int CNT_W    = 16
) (
   input logic                            clk,
   input logic                            rst_n,
   input logic                            tick_fast,
   input logic                            tick_slow,
   input logic                            wdt_rst_o,
   input logic [N_TIMERS-1:0]             ch_en,
   input logic [N_TIMERS-1:0]             ch_exp,
   input logic [N_TIMERS-1:0]             ch_busy,
   input logic [N_TIMERS-1:0]             ch_arm,
   input logic [N_TIMERS-1:0]             ch_svc,
   input logic [N_TIMERS-1:0][CNT_W-1:0]  ch_cnt,
   input logic [N_TIMERS-1:0][CNT_W-1:0]  ch_preset
);
   // R8
   slow_on_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick_slow |-> tick_fast);

   genvar gi;
   generate
      for (gi = 0; gi < N_TIMERS; gi++) begin : g_chk
         // R3
         arm_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_arm[gi] && !ch_busy[gi]) |=>
               (ch_en[gi] && ch_cnt[gi] == $past(ch_preset[gi])));
         // R5
         svc_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_svc[gi] && !ch_arm[gi] && ch_en[gi] && ch_cnt[gi] != '0) |=>
               (ch_cnt[gi] == $past(ch_preset[gi])));
         // R9
         expire_fires_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_en[gi] && ch_cnt[gi] == '0 && !ch_arm[gi]) |=>
               (ch_busy[gi] && !ch_en[gi] && wdt_rst_o));
         // R9
         busy_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ch_busy[gi] |-> !ch_en[gi]);
         // R10
         expired_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ch_exp[gi] |=> ch_exp[gi]);
         // R12
         cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_en[gi] && !ch_arm[gi] && !ch_svc[gi]) |=>
               (ch_cnt[gi] == $past(ch_cnt[gi]) ||
                ch_cnt[gi] == $past(ch_cnt[gi]) - 1'b1));
      end
   endgenerate
endmodule

bind wdt_dual_unit wdt_dual_chk #(
   .N_TIMERS (N_TIMERS),
   .CNT_W    (CNT_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tick_fast (tick_fast),
   .tick_slow (tick_slow),
   .wdt_rst_o (wdt_rst_o),
   .ch_en     (ch_en),
   .ch_exp    (ch_exp),
   .ch_busy   (ch_busy),
   .ch_arm    (ch_arm),
   .ch_svc    (ch_svc),
   .ch_cnt    (ch_cnt),
   .ch_preset (ch_preset)
);

// File: tb/wdt_dual_unit_tb.sv
module wdt_dual_unit_tb;
   localparam int NT   = 2;
   localparam int CW   = 16;
   localparam int DW   = 32;
   localparam int FD   = 2;
   localparam int SD   = 3;
   localparam int RC   = 4;
   localparam int AW   = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr = 1'b0;
   logic [AW-1:0] reg_addr = '0;
   logic [DW-1:0] reg_wdata = '0;
   logic [DW-1:0] reg_rdata;
   logic          wdt_rst;

   int n_vec = 0;
   int n_err = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   wdt_dual_unit #(
      .N_TIMERS   (NT),
      .CNT_W      (CW),
      .DATA_W     (DW),
      .FAST_DIV   (FD),
      .SLOW_DIV   (SD),
      .RST_CYCLES (RC)
   ) u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .reg_wr_i    (reg_wr),
      .reg_addr_i  (reg_addr),
      .reg_wdata_i (reg_wdata),
      .reg_rdata_o (reg_rdata),
      .wdt_rst_o   (wdt_rst)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_vec++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] ctl(input bit fast, input logic [1:0] svc, input logic [1:0] arm);
      return {27'b0, fast, svc, arm};
   endfunction

   task automatic wr(input int a, input logic [DW-1:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = AW'(a); reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic peek(input int a, output logic [DW-1:0] d);
      reg_addr = AW'(a);
      #1;
      d = reg_rdata;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic check_reset_state(input string tag);
      logic [DW-1:0] d;
      for (int t = 0; t < NT; t++) begin
         peek(2*t+1, d);
         chk(d == '0, {tag, " status"}, d, 0);
         peek(2*t, d);
         chk(d == '0, {tag, " preset"}, d, 0);
      end
      chk(wdt_rst == 1'b0, {tag, " rst_o"}, wdt_rst, 0);
   endtask

   task automatic run_expire(input int t, input bit fast, input int p);
      logic [DW-1:0] d;
      int period, prev, last, ndec, cyc, width, c;
      period = fast ? FD : FD*SD;
      wr(2*t, DW'(p));
      wr(2*t+1, ctl(fast, 2'b00, 2'b01));
      wr(2*t+1, ctl(fast, 2'b00, 2'b10));
      peek(2*t+1, d);
      chk(d[0] == 1'b1, "R3 armed", d[0], 1);
      chk(int'(d[31:16]) == p, "R3 count loaded", d[31:16], p);
      chk(d[2] == fast, "R2 select field", d[2], fast);
      prev = p; last = -1; ndec = 0; cyc = 0;
      while (prev != 0 && cyc < 200) begin
         @(negedge clk);
         peek(2*t+1, d);
         cyc++;
         c = int'(d[31:16]);
         if (c != prev) begin
            chk(c == prev - 1, "R12 single step", c, prev - 1);
            ndec++;
            if (last >= 0)
               chk(cyc - last == period, fast ? "R7 fast spacing" : "R8 slow spacing",
                   cyc - last, period);
            last = cyc;
            prev = c;
         end
      end
      chk(ndec == p, "R12 decrements to zero", ndec, p);
      chk(wdt_rst == 1'b0 && d[0] == 1'b1, "R9 no reset while count just hit zero", wdt_rst, 0);
      @(negedge clk);
      peek(2*t+1, d);
      chk(wdt_rst == 1'b1, "R9 reset one clock later", wdt_rst, 1);
      chk(d[0] == 1'b0, "R9 disabled on expiry", d[0], 0);
      width = 1;
      while (width < 50) begin
         @(negedge clk);
         peek(2*t+1, d);
         if (!wdt_rst) break;
         chk(d[1] == 1'b0, "R10 expired not early", d[1], 0);
         width++;
      end
      chk(width == RC, "R9 reset width", width, RC);
      chk(d[1] == 1'b1, "R10 expired set", d[1], 1);
      peek(2*(1-t)+1, d);
      chk(d == '0, "R11 other channel untouched", d, 0);
      wr(2*t+1, ctl(fast, 2'b01, 2'b00));
      wr(2*t+1, ctl(fast, 2'b10, 2'b00));
      peek(2*t+1, d);
      chk(d[1] == 1'b1, "R10 expired sticky", d[1], 1);
      do_reset();
      check_reset_state("R1/R10 cleared by reset");
   endtask

   initial begin
      logic [DW-1:0] d;
      int c1, c2, c3;
      do_reset();
      check_reset_state("R1 reset state");

      for (int t = 0; t < NT; t++)
         for (int f = 0; f < 2; f++)
            for (int p = 1; p <= 4; p++)
               run_expire(t, f[0], p);

      // arming key patterns, slow tick, long preset
      wr(0, DW'(1000));
      wr(1, ctl(1'b0, 2'b00, 2'b10));
      peek(1, d);
      chk(d[0] == 1'b0, "R4 lone close", d[0], 0);
      wr(1, ctl(1'b0, 2'b00, 2'b01));
      wr(1, ctl(1'b0, 2'b00, 2'b00));
      wr(1, ctl(1'b0, 2'b00, 2'b10));
      peek(1, d);
      chk(d[0] == 1'b0, "R4 interrupted", d[0], 0);
      wr(1, ctl(1'b0, 2'b00, 2'b01));
      wr(1, ctl(1'b0, 2'b00, 2'b11));
      wr(1, ctl(1'b0, 2'b00, 2'b10));
      peek(1, d);
      chk(d[0] == 1'b0, "R4 interrupted by 11", d[0], 0);
      wr(1, ctl(1'b0, 2'b00, 2'b01));
      wr(1, ctl(1'b0, 2'b00, 2'b01));
      wr(1, ctl(1'b0, 2'b00, 2'b10));
      peek(1, d);
      chk(d[0] == 1'b1, "R3 restarted open then close", d[0], 1);
      chk(d[2] == 1'b0, "R8 slow selected", d[2], 0);

      // service
      repeat (30) @(negedge clk);
      peek(1, d);
      c1 = int'(d[31:16]);
      chk(c1 >= 993 && c1 <= 996, "R8 slow progress", c1, 995);
      wr(1, ctl(1'b0, 2'b01, 2'b00));
      wr(1, ctl(1'b0, 2'b10, 2'b00));
      peek(1, d);
      chk(int'(d[31:16]) == 1000, "R5 service reload", d[31:16], 1000);
      repeat (30) @(negedge clk);
      peek(1, d);
      c2 = int'(d[31:16]);
      wr(1, ctl(1'b0, 2'b01, 2'b00));
      wr(1, ctl(1'b0, 2'b11, 2'b00));
      wr(1, ctl(1'b0, 2'b10, 2'b00));
      peek(1, d);
      c3 = int'(d[31:16]);
      chk(c3 <= c2 && c3 < 1000, "R6 broken service no reload", c3, c2);
      wr(1, ctl(1'b0, 2'b10, 2'b00));
      peek(1, d);
      chk(int'(d[31:16]) < 1000, "R6 lone service close", d[31:16], c3);

      // service on a disabled channel
      wr(2, DW'(50));
      wr(3, ctl(1'b0, 2'b01, 2'b00));
      wr(3, ctl(1'b0, 2'b10, 2'b00));
      peek(3, d);
      chk(d[0] == 1'b0, "R5 disabled stays disabled", d[0], 0);
      chk(d[31:16] == '0, "R5 disabled count unchanged", d[31:16], 0);
      peek(0, d);
      chk(d == DW'(1000), "R2 preset readback ch0", d, 1000);
      peek(2, d);
      chk(d == DW'(50), "R2 preset readback ch1", d, 50);
      chk(wdt_rst == 1'b0, "R11 no reset from idle channel", wdt_rst, 0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_vec++;
         n_err++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
         $finish;
      end
   end
endmodule